// File: doc/BRIEF.md
# Transmit Squelch and End-of-Frame Gate

This block sits between a serial Manchester transmit stream and the enable of a line driver. On each tick of a fixed sample clock it sees two sampled inputs: a flag saying the incoming signal is above the squelch threshold, and the data level itself. It opens the driver only after the above-threshold flag has held for a minimum number of consecutive samples. This keeps short noise spikes off the line.

Once open, the path passes data straight through. It closes in one of two ways. If the threshold flag drops, the path closes at once and can reopen after a fresh qualification. If the data stays high long enough to count as the end-of-packet idle, the path closes and a fixed blanking window starts. During that window all input activity is ignored, so trailing dribble pulses never reach the driver. A separate supervisor can mask the enable at any moment through an inhibit input.

Timing counts assume a 100 MHz sample clock:
- a 17 ns excursion is 2 samples,
- a 175 ns idle is 18 samples,
- a 0.8 us window is 80 cycles.

Top module: `tsq_gate`

## Requirements
- R1: A synchronous active-high reset sets `tx_en` to 0 and `tx_data` to 1, and puts the block in its idle state. This also applies when reset arrives in the middle of a transmission.
- R2: `tx_en` goes to 1 only after `sq_above` has been sampled high on QUAL_SAMPLES consecutive clock edges (default 2). It is 1 from the cycle after the last of those edges.
- R3: An above-threshold excursion shorter than QUAL_SAMPLES samples never raises `tx_en`. The block returns to idle. A run of w samples with w at or above QUAL_SAMPLES gives exactly w-QUAL_SAMPLES+1 enabled cycles when `din` is held low.
- R4: While enabled, a sample with `sq_above` low clears `tx_en` after that edge, and no blanking follows. With `sq_above` high again, `tx_en` returns after exactly QUAL_SAMPLES more samples.
- R5: While enabled, IDLE_SAMPLES consecutive samples of `din` high (default 18) clear `tx_en`. Any run of high samples shorter than that leaves `tx_en` at 1.
- R6: After the idle of R5, `tx_en` stays 0 for BLANK_CYCLES cycles (default 80), whatever `sq_above` and `din` do. Only then does a new qualification begin. With `sq_above` held high, `tx_en` is therefore 0 for BLANK_CYCLES+QUAL_SAMPLES samples.
- R7: `tx_data` equals `din` while `tx_en` is 1. It is held at 1 (the no-current level) while `tx_en` is 0.
- R8: `jab_inhibit` high forces `tx_en` to 0 in the same cycle, with no clock edge needed. The internal state is not changed, so releasing the inhibit during a transmission restores `tx_en` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| sq_above | input | 1 | Sampled flag: signal above squelch threshold |
| din | input | 1 | Sampled transmit data level |
| jab_inhibit | input | 1 | Enable mask from the jabber supervisor |
| tx_en | output | 1 | Line driver enable |
| tx_data | output | 1 | Gated data to the driver, 1 when disabled |

## Verification
Isolated threshold pulses of every width from zero to six samples separate the rejected widths from the accepted ones. Counting the enabled cycles for each width also pins down the exact opening edge.

High data runs are swept from 1 to 20 samples inside an open transmission. This finds the single run length at which the idle detector fires, and shows that a run one sample shorter does nothing.

The blanking window is measured with `din` toggling every cycle. A drop of the threshold flag, by contrast, reopens after only the qualification delay. Together these show which closing path was taken. Jabber inhibit and data gating are checked cycle by cycle inside an open transmission.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_QUAL = 2'd1,
        ST_ACT  = 2'd2,
        ST_BLNK = 2'd3
    } tsq_state_e;

    // width of a counter able to hold 0..limit
    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/tsq_run_counter.sv
module tsq_run_counter #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic hit
);
    localparam int W = tsq_pkg::cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = run && (cnt == LAST);

    // count never exceeds its terminal value
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // a dropped run restarts from zero
    p_cnt_clear_r3: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

endmodule

// File: rtl/tsq_fsm.sv
module tsq_fsm
    import tsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sq_above,
    input  logic       qual_hit,
    input  logic       idle_hit,
    input  logic       blank_done,
    output tsq_state_e state
);
    tsq_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (qual_hit)      nxt = ST_ACT;
                else if (sq_above) nxt = ST_QUAL;
            end
            ST_QUAL: begin
                if (!sq_above)     nxt = ST_IDLE;
                else if (qual_hit) nxt = ST_ACT;
            end
            ST_ACT: begin
                if (!sq_above)     nxt = ST_IDLE;
                else if (idle_hit) nxt = ST_BLNK;
            end
            ST_BLNK: begin
                if (blank_done)    nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // entry into ACTIVE only through a qualifying sample
    p_enter_act_r2: assert property (@(posedge clk) disable iff (rst)
        (state != ST_ACT && qual_hit && sq_above) |=> (state == ST_ACT));

    // losing the threshold while active goes straight to idle, not blank
    p_loss_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACT && !sq_above) |=> (state == ST_IDLE));

    // blank only ends when the window timer reports done
    p_blank_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BLNK && !blank_done) |=> (state == ST_BLNK));

endmodule

// File: rtl/tsq_gate.sv
module tsq_gate
    import tsq_pkg::*;
#(
    parameter int QUAL_SAMPLES = 2,
    parameter int IDLE_SAMPLES = 18,
    parameter int BLANK_CYCLES = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic sq_above,
    input  logic din,
    input  logic jab_inhibit,
    output logic tx_en,
    output logic tx_data
);
    tsq_state_e state;
    logic qual_hit, idle_hit, blank_done;
    logic qual_run, idle_run, blank_run;

    assign qual_run  = sq_above && (state == ST_IDLE || state == ST_QUAL);
    assign idle_run  = (state == ST_ACT) && din;
    assign blank_run = (state == ST_BLNK);

    tsq_run_counter #(.LIMIT(QUAL_SAMPLES)) u_qual (
        .clk(clk), .rst(rst), .run(qual_run), .hit(qual_hit)
    );

    tsq_run_counter #(.LIMIT(IDLE_SAMPLES)) u_idle (
        .clk(clk), .rst(rst), .run(idle_run), .hit(idle_hit)
    );

    tsq_run_counter #(.LIMIT(BLANK_CYCLES)) u_blank (
        .clk(clk), .rst(rst), .run(blank_run), .hit(blank_done)
    );

    tsq_fsm u_fsm (
        .clk(clk), .rst(rst), .sq_above(sq_above),
        .qual_hit(qual_hit), .idle_hit(idle_hit),
        .blank_done(blank_done), .state(state)
    );

    assign tx_en   = (state == ST_ACT) && !jab_inhibit;
    assign tx_data = din | ~tx_en;

    // inhibit masks the enable regardless of state
    p_jab_mask_r8: assert property (@(posedge clk) disable iff (rst)
        jab_inhibit |-> !tx_en);

    // disabled path holds the driver at the no-current level
    p_gate_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> tx_data);

    // no enable anywhere inside the blanking window
    p_blank_off_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BLNK) |-> !tx_en);

    // reset leaves the driver off
    p_reset_off_r1: assert property (@(posedge clk)
        rst |=> !tx_en);

endmodule

// File: tb/sim_tsq_gate.sv
module sim_tsq_gate;
    localparam int CLK_NS = 10;
    localparam int QS = 2;
    localparam int IS = 18;
    localparam int BC = 80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sq_above = 1'b0;
    logic din = 1'b0;
    logic jab_inhibit = 1'b0;
    logic tx_en, tx_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    tsq_gate #(.QUAL_SAMPLES(QS), .IDLE_SAMPLES(IS), .BLANK_CYCLES(BC)) u0 (
        .clk(clk), .rst(rst), .sq_above(sq_above), .din(din),
        .jab_inhibit(jab_inhibit), .tx_en(tx_en), .tx_data(tx_data)
    );

    always #(CLK_NS/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // drive at the falling edge, sample just after: result of previous rising edge
    task automatic step(input logic a, input logic d, input logic j);
        @(negedge clk);
        sq_above = a; din = d; jab_inhibit = j;
        #1;
    endtask

    task automatic settle();
        for (int i = 0; i < BC + 20; i++) step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic qualify();
        for (int i = 0; i < QS + 1; i++) step(1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        int cnt;
        int gbad;

        // R1: reset state
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R1 tx_en after reset", tx_en, 0);
        chk("R1 tx_data after reset", tx_data, 1);
        @(negedge clk); rst = 1'b0;
        settle();

        // R2/R3: pulse width sweep
        for (int w = 0; w <= 6; w++) begin
            cnt = 0;
            for (int k = 1; k <= 12; k++) begin
                step(k <= w, 1'b0, 1'b0);
                if (tx_en) cnt++;
            end
            chk($sformatf("R3 R2 width %0d enabled cycles", w), cnt,
                (w >= QS) ? (w - QS + 1) : 0);
            settle();
        end

        // R5: high-run sweep inside a transmission
        for (int h = 1; h <= 20; h++) begin
            qualify();
            for (int k = 0; k < h; k++) step(1'b1, 1'b1, 1'b0);
            step(1'b1, 1'b0, 1'b0);
            chk($sformatf("R5 high run %0d", h), tx_en, (h < IS) ? 1 : 0);
            settle();
        end

        // R6: blanking length with toggling data
        qualify();
        for (int k = 0; k < IS; k++) step(1'b1, 1'b1, 1'b0);
        cnt = 0; gbad = 0;
        for (int i = 0; i < 200; i++) begin
            step(1'b1, i[0], 1'b0);
            if (tx_en) break;
            cnt++;
            if (tx_data !== 1'b1) gbad++;
        end
        chk("R6 disabled samples after idle", cnt, BC + QS);
        chk("R7 tx_data high while blanked", gbad, 0);
        settle();

        // R4: squelch loss reopens after qualification only
        qualify();
        step(1'b1, 1'b0, 1'b0);
        chk("R4 enabled before loss", tx_en, 1);
        step(1'b0, 1'b0, 1'b0);
        cnt = 0;
        for (int i = 0; i < 200; i++) begin
            step(1'b1, 1'b0, 1'b0);
            if (tx_en) break;
            cnt++;
        end
        chk("R4 disabled samples after loss", cnt, QS);

        // R7: data passes while enabled
        gbad = 0;
        for (int i = 0; i < 16; i++) begin
            step(1'b1, ((i * 5) % 3) == 1, 1'b0);
            if (tx_data !== din || tx_en !== 1'b1) gbad++;
        end
        chk("R7 tx_data follows din when enabled", gbad, 0);

        // R8: inhibit is immediate and leaves state intact
        step(1'b1, 1'b0, 1'b1);
        chk("R8 tx_en under inhibit", tx_en, 0);
        chk("R8 R7 tx_data under inhibit", tx_data, 1);
        step(1'b1, 1'b0, 1'b0);
        chk("R8 tx_en after inhibit release", tx_en, 1);

        // R1: reset in mid-transmission
        @(negedge clk); rst = 1'b1;
        step(1'b1, 1'b0, 1'b0);
        chk("R1 tx_en after mid-frame reset", tx_en, 0);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 tx_en stays low after reset release", tx_en, 0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule